// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between an ADC core and its output serializer. It either passes the live conversion result through, or puts a known test word in its place so that a receiver can validate its capture path and timing. A 4-bit mode code selects the source. The choices are:

- live data;
- several fixed words;
- two-word patterns that alternate on every sample;
- a pair of user-programmed words;
- two pseudo-random bit sequence generators, a short one of 9 stages and a long one of 23 stages.

Each sample clock produces one word. The word goes out on a 14-bit frame bus and is left-justified, so the first serialized bit sits at bit 13. A word-length code shortens the frame to 8 or 10 bits, or extends it to 14 bits. Beside each word, the block raises a flag that tells the next stage whether its data-format conversion (offset binary to two's complement, for example) should be applied to the word.

Top module: `adc_pattern_gen`

## Requirements
- R1: While `rstN` is low, `patData` and `fmtApply` are both 0.
- R2: Mode codes 0, 13, 14 and 15 pass `liveData` through. The 12-bit value sits in `patData[13:2]`.
- R3: The fixed-word modes map to these 12-bit words in `patData[13:2]`. Mode 1 gives 0x800, mode 2 gives 0xFFF, mode 3 gives 0x000, mode 9 gives 0xAAA, mode 10 gives 0x03F, mode 11 gives 0x800, and mode 12 gives 0xA33.
- R4: Mode 4 alternates between 0xAAA and 0x555 on successive samples.
- R5: Mode 7 alternates between 0xFFF and 0x000 on successive samples.
- R6: Mode 8 alternates between two user words. The first is {`usrW1Hi`, `usrW1Lo[7:4]`} and the second is {`usrW2Hi`, `usrW2Lo[7:4]`}.
- R7: Every alternating mode emits its first word on the first sample after the mode code changes, or after reset, and then toggles on every sample.
- R8: `lenSel` selects the word length: 0 is 12 bits, 1 is 8 bits, 2 is 10 bits and 3 is 14 bits. Frame bits below the selected length are forced to 0, so the 8-bit length zeroes `patData[5:0]` and the 10-bit length zeroes `patData[3:0]`. The 12-bit and 14-bit lengths both leave `patData[1:0]` at 0. This rule applies to every mode except the two PN modes.
- R9: `fmtApply` is 1 for modes 0, 1, 2, 3, 5, 6, 13, 14 and 15, and 0 for all other modes.
- R10: Mode 6 emits the short PN sequence.
  - The 9-bit state `s` starts from `SHORT_SEED`. Each step outputs `s[8]` and shifts `s` left, taking in `s[8]^s[4]`.
  - Each sample takes 12 steps, and the first bit goes to `patData[13]`.
  - The sequence repeats every 511 samples.
  - The state reloads its seed each time the mode is entered.
- R11: Mode 5 emits the long PN sequence. It works in the same way as R10, but uses a 23-bit state seeded from `LONG_SEED` and takes in `s[22]^s[17]`.
- R12: The PN modes ignore `lenSel`. They always fill `patData[13:2]` and leave `patData[1:0]` at 0.
- R13: Each output appears one clock after the inputs that produced it are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 4 | Test pattern mode code |
| lenSel | input | 2 | Word length code |
| liveData | input | 12 | Live ADC sample |
| usrW1Hi | input | 8 | First user word, upper byte |
| usrW1Lo | input | 8 | First user word, low nibble in bits 7:4 |
| usrW2Hi | input | 8 | Second user word, upper byte |
| usrW2Lo | input | 8 | Second user word, low nibble in bits 7:4 |
| patData | output | 14 | Left-justified output frame |
| fmtApply | output | 1 | Data-format conversion applies to this word |

## Verification
The bench uses the default parameters: a 9-stage short generator with seed 0x0DF and a 23-stage long generator with seed 0x29B80A. With those seeds, a run of a little over 511 samples covers the full period of the short sequence, so the bench can confirm that the sequence wraps back on itself. The long sequence is compared word by word against a bit-level model for a few hundred samples. The bench also re-enters the short mode to confirm that the seed reloads, and switches the length code in the middle of the PN run to confirm that the PN words are unaffected.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int RAW_W   = 12;
  localparam int FRAME_W = 14;
  localparam int USR_W   = 8;
  localparam int NIB_W   = RAW_W - USR_W;
  localparam int PAD_W   = FRAME_W - RAW_W;

  localparam logic [3:0] MODE_LIVE    = 4'd0;
  localparam logic [3:0] MODE_MID     = 4'd1;
  localparam logic [3:0] MODE_POSFS   = 4'd2;
  localparam logic [3:0] MODE_NEGFS   = 4'd3;
  localparam logic [3:0] MODE_CHECKER = 4'd4;
  localparam logic [3:0] MODE_PNLONG  = 4'd5;
  localparam logic [3:0] MODE_PNSHORT = 4'd6;
  localparam logic [3:0] MODE_WTOGGLE = 4'd7;
  localparam logic [3:0] MODE_USER    = 4'd8;
  localparam logic [3:0] MODE_BTOGGLE = 4'd9;
  localparam logic [3:0] MODE_SYNC    = 4'd10;
  localparam logic [3:0] MODE_ONEHIGH = 4'd11;
  localparam logic [3:0] MODE_MIXED   = 4'd12;

  localparam logic [1:0] LEN_12 = 2'd0;
  localparam logic [1:0] LEN_8  = 2'd1;
  localparam logic [1:0] LEN_10 = 2'd2;
  localparam logic [1:0] LEN_14 = 2'd3;

  typedef struct packed {
    logic entry;
    logic phase;
    logic shortLoad;
    logic shortAdv;
    logic longLoad;
    logic longAdv;
  } pat_ctl_t;
endpackage

// File: rtl/pat_lfsr.sv
module pat_lfsr #(
  parameter int W = 9,
  parameter int TAP = 5,
  parameter logic [W-1:0] SEED = 9'h0DF,
  parameter int STEP = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            load,
  input  logic            adv,
  output logic [STEP-1:0] word
);
  logic [W-1:0] state;
  logic [W-1:0] srcState;
  logic [W-1:0] nextState;

  function automatic logic [W+STEP-1:0] runSteps(input logic [W-1:0] s0);
    logic [W-1:0] s;
    logic [STEP-1:0] w;
    logic fb;
    s = s0;
    w = '0;
    for (int i = 0; i < STEP; i++) begin
      w[STEP-1-i] = s[W-1];
      fb = s[W-1] ^ s[TAP-1];
      s = {s[W-2:0], fb};
    end
    return {w, s};
  endfunction

  always_comb begin
    srcState = load ? SEED : state;
    {word, nextState} = runSteps(srcState);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else if (load || adv) state <= nextState;
  end

  // R10 / R11: a maximal-length register never falls into the all-zero lockup
  assert_state_nonzero_R10: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);
endmodule

// File: rtl/pat_ctrl.sv
module pat_ctrl
  import pat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] modeIn,
  output pat_ctl_t   ctl
);
  logic       started;
  logic [3:0] prevMode;
  logic       phaseReg;
  logic       entry;

  assign entry = !started || (modeIn != prevMode);

  always_comb begin
    ctl.entry     = entry;
    ctl.phase     = entry ? 1'b0 : phaseReg;
    ctl.shortLoad = entry && (modeIn == MODE_PNSHORT);
    ctl.shortAdv  = !entry && (modeIn == MODE_PNSHORT);
    ctl.longLoad  = entry && (modeIn == MODE_PNLONG);
    ctl.longAdv   = !entry && (modeIn == MODE_PNLONG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started  <= 1'b0;
      prevMode <= '0;
      phaseReg <= 1'b0;
    end else begin
      started  <= 1'b1;
      prevMode <= modeIn;
      phaseReg <= ~ctl.phase;
    end
  end

  // R7: a held mode yields word 2 right after word 1 has been issued
  assert_phase_second_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.entry |=> (ctl.entry || ctl.phase));
endmodule

// File: rtl/pat_datapath.sv
module pat_datapath
  import pat_pkg::*;
#(
  parameter logic [8:0]  SHORT_SEED = 9'h0DF,
  parameter logic [22:0] LONG_SEED  = 23'h29B80A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         modeIn,
  input  logic [1:0]         lenSel,
  input  logic [RAW_W-1:0]   liveIn,
  input  logic [USR_W-1:0]   usrW1Hi,
  input  logic [USR_W-1:0]   usrW1Lo,
  input  logic [USR_W-1:0]   usrW2Hi,
  input  logic [USR_W-1:0]   usrW2Lo,
  input  pat_ctl_t           ctl,
  output logic [FRAME_W-1:0] patData,
  output logic               fmtApply
);
  localparam logic [RAW_W-1:0] W_MID     = RAW_W'(1) << (RAW_W - 1);
  localparam logic [RAW_W-1:0] W_ONES    = '1;
  localparam logic [RAW_W-1:0] W_ALT     = {(RAW_W/2){2'b10}};
  localparam logic [RAW_W-1:0] W_SYNC    = (RAW_W'(1) << (RAW_W / 2)) - RAW_W'(1);
  localparam logic [RAW_W-1:0] W_MIXED   = 12'hA33;

  logic [RAW_W-1:0]   shortWord, longWord;
  logic [RAW_W-1:0]   rawWord;
  logic [RAW_W-1:0]   usrWord1, usrWord2;
  logic               isPn, fmtNext;
  logic [FRAME_W-1:0] frame, lenMask, frameNext;
  logic               unusedLowBits;

  assign usrWord1 = {usrW1Hi, usrW1Lo[USR_W-1 -: NIB_W]};
  assign usrWord2 = {usrW2Hi, usrW2Lo[USR_W-1 -: NIB_W]};
  assign unusedLowBits = ^{usrW1Lo[USR_W-NIB_W-1:0], usrW2Lo[USR_W-NIB_W-1:0]};

  pat_lfsr #(.W(9), .TAP(5), .SEED(SHORT_SEED), .STEP(RAW_W)) u_short (
    .clk(clk), .rstN(rstN), .load(ctl.shortLoad), .adv(ctl.shortAdv), .word(shortWord)
  );

  pat_lfsr #(.W(23), .TAP(18), .SEED(LONG_SEED), .STEP(RAW_W)) u_long (
    .clk(clk), .rstN(rstN), .load(ctl.longLoad), .adv(ctl.longAdv), .word(longWord)
  );

  always_comb begin
    isPn    = 1'b0;
    fmtNext = 1'b0;
    case (modeIn)
      MODE_MID:     begin rawWord = W_MID;  fmtNext = 1'b1; end
      MODE_POSFS:   begin rawWord = W_ONES; fmtNext = 1'b1; end
      MODE_NEGFS:   begin rawWord = '0;     fmtNext = 1'b1; end
      MODE_CHECKER: rawWord = ctl.phase ? ~W_ALT : W_ALT;
      MODE_PNLONG:  begin rawWord = longWord;  isPn = 1'b1; fmtNext = 1'b1; end
      MODE_PNSHORT: begin rawWord = shortWord; isPn = 1'b1; fmtNext = 1'b1; end
      MODE_WTOGGLE: rawWord = ctl.phase ? '0 : W_ONES;
      MODE_USER:    rawWord = ctl.phase ? usrWord2 : usrWord1;
      MODE_BTOGGLE: rawWord = W_ALT;
      MODE_SYNC:    rawWord = W_SYNC;
      MODE_ONEHIGH: rawWord = W_MID;
      MODE_MIXED:   rawWord = W_MIXED;
      default:      begin rawWord = liveIn; fmtNext = 1'b1; end
    endcase
  end

  always_comb begin
    case (lenSel)
      LEN_8:   lenMask = {FRAME_W{1'b1}} << (FRAME_W - 8);
      LEN_10:  lenMask = {FRAME_W{1'b1}} << (FRAME_W - 10);
      LEN_12:  lenMask = {FRAME_W{1'b1}} << (FRAME_W - 12);
      default: lenMask = {FRAME_W{1'b1}};
    endcase
    frame     = {rawWord, {PAD_W{1'b0}}};
    frameNext = isPn ? frame : (frame & lenMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patData  <= '0;
      fmtApply <= 1'b0;
    end else begin
      patData  <= frameNext;
      fmtApply <= fmtNext;
    end
  end

  assert_mid_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == MODE_MID) |=> (patData[13:6] == 8'h80));

  assert_checker_alt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == MODE_CHECKER && !ctl.entry) |=> (patData[13:6] != $past(patData[13:6])));

  assert_len8_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lenSel == LEN_8 && modeIn != MODE_PNSHORT && modeIn != MODE_PNLONG)
      |=> (patData[5:0] == 6'd0));

  assert_live_fmt_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == MODE_LIVE) |=> fmtApply);

  assert_pn_tail_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == MODE_PNSHORT || modeIn == MODE_PNLONG) |=> (patData[1:0] == 2'b00));
endmodule

// File: rtl/adc_pattern_gen.sv
module adc_pattern_gen
  import pat_pkg::*;
#(
  parameter logic [8:0]  SHORT_SEED = 9'h0DF,
  parameter logic [22:0] LONG_SEED  = 23'h29B80A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  modeSel,
  input  logic [1:0]  lenSel,
  input  logic [11:0] liveData,
  input  logic [7:0]  usrW1Hi,
  input  logic [7:0]  usrW1Lo,
  input  logic [7:0]  usrW2Hi,
  input  logic [7:0]  usrW2Lo,
  output logic [13:0] patData,
  output logic        fmtApply
);
  pat_ctl_t ctl;

  pat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeSel), .ctl(ctl)
  );

  pat_datapath #(.SHORT_SEED(SHORT_SEED), .LONG_SEED(LONG_SEED)) u_dp (
    .clk(clk), .rstN(rstN), .modeIn(modeSel), .lenSel(lenSel), .liveIn(liveData),
    .usrW1Hi(usrW1Hi), .usrW1Lo(usrW1Lo), .usrW2Hi(usrW2Hi), .usrW2Lo(usrW2Lo),
    .ctl(ctl), .patData(patData), .fmtApply(fmtApply)
  );
endmodule

// File: tb/adc_pattern_gen_tb.sv
module adc_pattern_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  modeSel = 4'd0;
  logic [1:0]  lenSel = 2'd0;
  logic [11:0] liveData = 12'd0;
  logic [7:0]  usrW1Hi = 8'd0, usrW1Lo = 8'd0, usrW2Hi = 8'd0, usrW2Lo = 8'd0;
  logic [13:0] patData;
  logic        fmtApply;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [8:0]  S_SEED = 9'h0DF;
  localparam logic [22:0] L_SEED = 23'h29B80A;

  always #10ns clk = ~clk;

  adc_pattern_gen u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .lenSel(lenSel), .liveData(liveData),
    .usrW1Hi(usrW1Hi), .usrW1Lo(usrW1Lo), .usrW2Hi(usrW2Hi), .usrW2Lo(usrW2Lo),
    .patData(patData), .fmtApply(fmtApply)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [1:0]  len;
    logic [11:0] live;
    logic [13:0] exp1;
    logic [13:0] exp2;
    logic        fmt;
  } vec_t;

  localparam vec_t VECS [0:15] = '{
    '{4'd0,  2'd0, 12'hABC, 14'h2AF0, 14'h2AF0, 1'b1},
    '{4'd1,  2'd0, 12'h000, 14'h2000, 14'h2000, 1'b1},
    '{4'd2,  2'd0, 12'h000, 14'h3FFC, 14'h3FFC, 1'b1},
    '{4'd3,  2'd0, 12'hFFF, 14'h0000, 14'h0000, 1'b1},
    '{4'd4,  2'd0, 12'h000, 14'h2AA8, 14'h1554, 1'b0},
    '{4'd7,  2'd0, 12'h000, 14'h3FFC, 14'h0000, 1'b0},
    '{4'd9,  2'd0, 12'h000, 14'h2AA8, 14'h2AA8, 1'b0},
    '{4'd10, 2'd0, 12'h000, 14'h00FC, 14'h00FC, 1'b0},
    '{4'd11, 2'd0, 12'h000, 14'h2000, 14'h2000, 1'b0},
    '{4'd12, 2'd0, 12'h000, 14'h28CC, 14'h28CC, 1'b0},
    '{4'd13, 2'd0, 12'h123, 14'h048C, 14'h048C, 1'b1},
    '{4'd15, 2'd1, 12'hFFF, 14'h3FC0, 14'h3FC0, 1'b1},
    '{4'd4,  2'd2, 12'h000, 14'h2AA0, 14'h1550, 1'b0},
    '{4'd2,  2'd3, 12'h000, 14'h3FFC, 14'h3FFC, 1'b1},
    '{4'd12, 2'd1, 12'h000, 14'h28C0, 14'h28C0, 1'b0},
    '{4'd14, 2'd0, 12'h5A5, 14'h1694, 14'h1694, 1'b1}
  };

  function automatic string tagOf(input logic [3:0] m, input logic [1:0] l);
    if (l != 2'd0) return "R8";
    case (m)
      4'd4:    return "R4";
      4'd7:    return "R5";
      4'd0, 4'd13, 4'd14, 4'd15: return "R2";
      default: return "R3";
    endcase
  endfunction

  // Bit-level PN models taken from the requirement text
  function automatic logic [20:0] shortModel(input logic [8:0] s0);
    logic [8:0] s = s0;
    logic [11:0] w = '0;
    for (int i = 0; i < 12; i++) begin
      w = {w[10:0], s[8]};
      s = {s[7:0], s[8] ^ s[4]};
    end
    return {w, s};
  endfunction

  function automatic logic [34:0] longModel(input logic [22:0] s0);
    logic [22:0] s = s0;
    logic [11:0] w = '0;
    for (int i = 0; i < 12; i++) begin
      w = {w[10:0], s[22]};
      s = {s[21:0], s[22] ^ s[17]};
    end
    return {w, s};
  endfunction

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0]  sState;
    logic [22:0] lState;
    logic [20:0] sRes;
    logic [34:0] lRes;
    logic [13:0] firstWords [0:19];
    logic [13:0] seedWord;

    // R1: reset state
    repeat (3) sample();
    chk("R1", patData, 14'h0000);
    chk("R1", {13'd0, fmtApply}, 14'd0);
    rstN = 1'b1;

    // Table walk: each row enters a new mode, then holds it for two samples
    for (int r = 0; r < 16; r++) begin
      modeSel  = VECS[r].mode;
      lenSel   = VECS[r].len;
      liveData = VECS[r].live;
      sample();
      chk(tagOf(VECS[r].mode, VECS[r].len), patData, VECS[r].exp1);
      chk("R9", {13'd0, fmtApply}, {13'd0, VECS[r].fmt});
      sample();
      chk("R7", patData, VECS[r].exp2);
    end

    // R6: user words alternate, first word first
    lenSel = 2'd0;
    usrW1Hi = 8'hC3; usrW1Lo = 8'h5F; usrW2Hi = 8'h1E; usrW2Lo = 8'h80;
    modeSel = 4'd8;
    for (int k = 0; k < 4; k++) begin
      sample();
      chk("R6", patData, (k % 2 == 0) ? 14'h30D4 : 14'h07A0);
      chk("R9", {13'd0, fmtApply}, 14'd0);
    end

    // R7: three samples of mode 7, one of mode 4, then mode 7 restarts at word 1
    modeSel = 4'd7;
    sample(); chk("R5", patData, 14'h3FFC);
    sample(); chk("R5", patData, 14'h0000);
    sample(); chk("R5", patData, 14'h3FFC);
    modeSel = 4'd4;
    sample(); chk("R7", patData, 14'h2AA8);
    modeSel = 4'd7;
    sample(); chk("R7", patData, 14'h3FFC);

    // R13: one-clock latency on live data
    modeSel = 4'd0;
    liveData = 12'h111;
    sample();
    chk("R13", patData, 14'h0444);
    liveData = 12'h222;
    #1ns;
    chk("R13", patData, 14'h0444);
    sample();
    chk("R13", patData, 14'h0888);

    // R10 / R12: short PN, full period, length code ignored after sample 100
    modeSel = 4'd6;
    lenSel = 2'd0;
    sState = S_SEED;
    for (int k = 0; k < 540; k++) begin
      if (k == 100) lenSel = 2'd1;
      sRes = shortModel(sState);
      sState = sRes[8:0];
      sample();
      if (k < 100) chk("R10", patData, {sRes[20:9], 2'b00});
      else         chk("R12", patData, {sRes[20:9], 2'b00});
      if (k < 20) firstWords[k] = patData;
      if (k >= 511 && k < 531) chk("R10", patData, firstWords[k-511]);
    end
    chk("R9", {13'd0, fmtApply}, 14'd1);

    // R10: leaving and re-entering reloads the seed
    seedWord = {shortModel(S_SEED)[20:9], 2'b00};
    modeSel = 4'd0;
    lenSel = 2'd0;
    sample();
    modeSel = 4'd6;
    sample();
    chk("R10", patData, seedWord);

    // R11: long PN against model
    modeSel = 4'd5;
    lState = L_SEED;
    for (int k = 0; k < 300; k++) begin
      lRes = longModel(lState);
      lState = lRes[22:0];
      sample();
      chk("R11", patData, {lRes[34:23], 2'b00});
    end
    chk("R9", {13'd0, fmtApply}, 14'd1);

    // R1: reset in the middle of operation clears outputs
    rstN = 1'b0;
    #1ns;
    chk("R1", patData, 14'h0000);
    chk("R1", {13'd0, fmtApply}, 14'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule